// File: doc/BRIEF.md
# Serial Port Register File

This block is the software-visible front of a simple serial port. A processor reaches it through a word-aligned register bus. Behind it sit a bit serializer, which takes one byte per strobe, and a deserializer, which hands over one byte or a line-break event per strobe. The serial timing lives in those neighbours. This block holds the control words, the status flags and a receive buffer that is one character deep.

Bus reads have no wait states: read data is combinational from the current state. Every effect of an access, such as consuming a received character, clearing flags or resetting under software control, takes hold at the clock edge that ends the access. The single interrupt line is registered, so it reflects the state one cycle after that state changes.

Top module: `uart_regfile`

## Requirements
- R1: After `rst_n` is released, reads return these values. Status 1 (word 0x25) reads 0x6040: transmit-ready bit 13, RTS-status bit 14 and receiver-idle bit 6 are set. Status 2 (word 0x26) reads 0x4028: TX-empty bit 14, DCD-in bit 5 and TX-complete bit 3 are set. The test register (word 0x2D) reads 0x0060: RX-empty bit 5 and TX-empty bit 6 are set. Control 1 (0x20) reads 0. Control 2 (0x21) reads 0x0001. Control 3 (0x22) reads 0x0700. The modulator (0x2A) reads 0 and the baud count (0x2B) reads 4. Receive data (0x00) reads 0x4000, the error code (bit 14). `irq` and `tx_strobe` are low.
- R2: A write to control 1, control 2, control 3, FIFO control (0x24), modulator (0x2A) or one-millisecond (0x2C) stores only bits 15:0 of the write data. A write to the baud increment word (0x29) stores bits 15:0 into the baud count, which reads back at 0x2B.
- R3: Reads of control 4 (0x23), baud increment (0x29) and any unmapped word return 0. Writes to control 4 and to the test register change nothing that can be read back.
- R4: An incoming byte (`rx_strobe`) is taken only while receive-ready (status 1 bit 9) is clear. Taking it stores the byte, sets receive-ready and receive-data-ready (status 2 bit 0), and clears RX-empty (test bit 5). A byte that arrives while the buffer is full is dropped.
- R5: A `rx_break` event is taken in the same way as a byte, and it stores the break code 0x0800 (bit 11).
- R6: Reading receive data while the buffer holds a character returns that character with bit 15 set. The same read clears receive-ready and receive-data-ready and sets RX-empty.
- R7: Reading receive data while the buffer is empty returns the stored value with bit 15 clear and changes no flag.
- R8: A write to transmit data (word 0x10) raises `tx_strobe` for exactly the next cycle, with `tx_byte` equal to write bits 7:0. This happens only while transmit-enable (control 2 bit 2) is set. Transmit-ready stays set throughout.
- R9: A write to status 1 clears only those bits written as one that lie in mask 0x9DB0. A write to status 2 clears only those bits written as one that lie in mask 0xBDD6. Ready, receive-data-ready and the other fixed flags are untouched.
- R10: `irq` is high one cycle after either of two conditions holds. The first is status 1 bit 9 and control 1 bit 9 both set. The second is status 1 bit 13, control 1 bit 13 and control 1 bit 6 (transmitter-empty enable) all set.
- R11: Writing control 2 with bit 0 clear restores the R1 values of status 1, status 2, test, control 1, control 3, modulator, baud count and the receive buffer. It leaves FIFO control and one-millisecond unchanged. Control 2 then holds the written bits 15:0 with bit 0 forced to one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits above 1 select the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| tx_strobe | output | 1 | One-cycle pulse carrying a byte to the serializer |
| tx_byte | output | 8 | Byte carried by `tx_strobe` |
| rx_strobe | input | 1 | Deserializer delivers a byte |
| rx_break | input | 1 | Deserializer reports a line break |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Level interrupt, registered |

## Verification
Some properties are checked by assertions on every cycle. The reset bit of control 2 must always read as one. Transmit-ready must never drop. Receive-ready must always be the inverse of RX-empty. A full receive buffer must hold its contents unless a bus access intervenes. A transmit strobe must be preceded by a write while transmit-enable was set. Other behaviour can only be shown by the bench's scenarios: the exact read values, the 16-bit masking, the clear masks of status 1 and status 2, the dropping of a second byte, the break code, the cycle in which `irq` rises and falls, and which registers survive a software reset.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned BYTE_W = 8;

    // word indices (byte offset >> 2)
    localparam int unsigned IDX_RXD  = 'h00;
    localparam int unsigned IDX_TXD  = 'h10;
    localparam int unsigned IDX_CTL1 = 'h20;
    localparam int unsigned IDX_CTL2 = 'h21;
    localparam int unsigned IDX_CTL3 = 'h22;
    localparam int unsigned IDX_CTL4 = 'h23;
    localparam int unsigned IDX_FIFO = 'h24;
    localparam int unsigned IDX_STS1 = 'h25;
    localparam int unsigned IDX_STS2 = 'h26;
    localparam int unsigned IDX_BINC = 'h29;
    localparam int unsigned IDX_BMOD = 'h2A;
    localparam int unsigned IDX_BCNT = 'h2B;
    localparam int unsigned IDX_MSEC = 'h2C;
    localparam int unsigned IDX_TEST = 'h2D;

    // bit positions
    localparam int unsigned B_C1_TXEIE = 6;
    localparam int unsigned B_C1_RXIE  = 9;
    localparam int unsigned B_C1_TXIE  = 13;
    localparam int unsigned B_C2_SRST  = 0;
    localparam int unsigned B_C2_TXEN  = 2;
    localparam int unsigned B_S1_RRDY  = 9;
    localparam int unsigned B_S1_TRDY  = 13;
    localparam int unsigned B_S2_RDR   = 0;
    localparam int unsigned B_TS_RXEMP = 5;
    localparam int unsigned B_RX_VALID = 15;

    localparam logic [REG_W-1:0] STS1_W1C   = 16'h9DB0;
    localparam logic [REG_W-1:0] STS2_W1C   = 16'hBDD6;
    localparam logic [REG_W-1:0] RX_ERRCODE = 16'h4000;
    localparam logic [REG_W-1:0] RX_BRKCODE = 16'h0800;

    typedef enum logic [3:0] {
        RID_NONE, RID_RXD, RID_TXD, RID_CTL1, RID_CTL2, RID_CTL3, RID_CTL4,
        RID_FIFO, RID_STS1, RID_STS2, RID_BINC, RID_BMOD, RID_BCNT, RID_MSEC,
        RID_TEST
    } reg_id_e;

    typedef struct packed {
        logic [REG_W-1:0] ctl1;
        logic [REG_W-1:0] ctl2;
        logic [REG_W-1:0] ctl3;
        logic [REG_W-1:0] fifo;
        logic [REG_W-1:0] sts1;
        logic [REG_W-1:0] sts2;
        logic [REG_W-1:0] test;
        logic [REG_W-1:0] bmod;
        logic [REG_W-1:0] bcnt;
        logic [REG_W-1:0] msec;
        logic [REG_W-1:0] rxbuf;
    } rf_regs_t;

    typedef struct packed {
        rf_regs_t          r;
        logic              tx_stb;
        logic [BYTE_W-1:0] tx_byte;
        logic              irq;
    } rf_state_t;

    localparam rf_regs_t REGS_INIT = '{
        ctl1:  16'h0000, ctl2: 16'h0001, ctl3: 16'h0700, fifo: 16'h0000,
        sts1:  16'h6040, sts2: 16'h4028, test: 16'h0060, bmod: 16'h0000,
        bcnt:  16'h0004, msec: 16'h0000, rxbuf: RX_ERRCODE
    };
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic [IDX_W-1:0] widx,
    output reg_id_e          id
);
    always_comb begin
        case (widx)
            IDX_W'(IDX_RXD):  id = RID_RXD;
            IDX_W'(IDX_TXD):  id = RID_TXD;
            IDX_W'(IDX_CTL1): id = RID_CTL1;
            IDX_W'(IDX_CTL2): id = RID_CTL2;
            IDX_W'(IDX_CTL3): id = RID_CTL3;
            IDX_W'(IDX_CTL4): id = RID_CTL4;
            IDX_W'(IDX_FIFO): id = RID_FIFO;
            IDX_W'(IDX_STS1): id = RID_STS1;
            IDX_W'(IDX_STS2): id = RID_STS2;
            IDX_W'(IDX_BINC): id = RID_BINC;
            IDX_W'(IDX_BMOD): id = RID_BMOD;
            IDX_W'(IDX_BCNT): id = RID_BCNT;
            IDX_W'(IDX_MSEC): id = RID_MSEC;
            IDX_W'(IDX_TEST): id = RID_TEST;
            default:          id = RID_NONE;
        endcase
    end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
    import uart_rf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  rf_regs_t          regs,
    input  reg_id_e           id,
    output logic [DATA_W-1:0] rdata
);
    logic [REG_W-1:0] rx_word;

    // valid flag when the buffer is occupied
    assign rx_word = regs.rxbuf
                   | (REG_W'(~regs.test[B_TS_RXEMP]) << B_RX_VALID);

    always_comb begin
        case (id)
            RID_RXD:  rdata = DATA_W'(rx_word);
            RID_CTL1: rdata = DATA_W'(regs.ctl1);
            RID_CTL2: rdata = DATA_W'(regs.ctl2);
            RID_CTL3: rdata = DATA_W'(regs.ctl3);
            RID_FIFO: rdata = DATA_W'(regs.fifo);
            RID_STS1: rdata = DATA_W'(regs.sts1);
            RID_STS2: rdata = DATA_W'(regs.sts2);
            RID_BMOD: rdata = DATA_W'(regs.bmod);
            RID_BCNT: rdata = DATA_W'(regs.bcnt);
            RID_MSEC: rdata = DATA_W'(regs.msec);
            RID_TEST: rdata = DATA_W'(regs.test);
            default:  rdata = '0;   // control 4, increment, unmapped
        endcase
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    input  logic              rx_strobe,
    input  logic              rx_break,
    input  logic [7:0]        rx_byte
    ,
    output logic              irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    rf_state_t        st_d, st_q;
    reg_id_e          id;
    rf_regs_t         rst_img;
    logic [REG_W-1:0] wlow;
    logic             rd_hit, wr_hit, rx_in;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:REG_W], bus_addr[1:0]};
    assign wlow        = bus_wdata[REG_W-1:0];
    assign rd_hit      = bus_en & ~bus_we;
    assign wr_hit      = bus_en &  bus_we;
    assign rx_in       = rx_strobe | rx_break;

    uart_rf_decode #(.IDX_W(IDX_W)) u_decode (
        .widx (bus_addr[ADDR_W-1:2]),
        .id   (id)
    );

    uart_rf_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .regs  (st_q.r),
        .id    (id),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.tx_stb = 1'b0;
        rst_img     = REGS_INIT;

        // interrupt follows the registered state one cycle later
        st_d.irq = (st_q.r.sts1[B_S1_RRDY] & st_q.r.ctl1[B_C1_RXIE])
                 | (st_q.r.sts1[B_S1_TRDY] & st_q.r.ctl1[B_C1_TXIE]
                    & st_q.r.ctl1[B_C1_TXEIE]);

        // deserializer side: only into an empty buffer
        if (rx_in && !st_q.r.sts1[B_S1_RRDY]) begin
            st_d.r.rxbuf               = rx_break ? RX_BRKCODE : REG_W'(rx_byte);
            st_d.r.sts1[B_S1_RRDY]     = 1'b1;
            st_d.r.sts2[B_S2_RDR]      = 1'b1;
            st_d.r.test[B_TS_RXEMP]    = 1'b0;
        end

        // consuming read
        if (rd_hit && id == RID_RXD && !st_q.r.test[B_TS_RXEMP]) begin
            st_d.r.sts1[B_S1_RRDY]  = 1'b0;
            st_d.r.sts2[B_S2_RDR]   = 1'b0;
            st_d.r.test[B_TS_RXEMP] = 1'b1;
        end

        if (wr_hit) begin
            case (id)
                RID_TXD: begin
                    if (st_q.r.ctl2[B_C2_TXEN]) begin
                        st_d.tx_stb  = 1'b1;
                        st_d.tx_byte = bus_wdata[BYTE_W-1:0];
                    end
                end
                RID_CTL1: st_d.r.ctl1 = wlow;
                RID_CTL2: begin
                    if (!wlow[B_C2_SRST]) begin
                        rst_img.fifo = st_d.r.fifo;
                        rst_img.msec = st_d.r.msec;
                        st_d.r       = rst_img;
                    end
                    st_d.r.ctl2 = wlow | (REG_W'(1) << B_C2_SRST);
                end
                RID_CTL3: st_d.r.ctl3 = wlow;
                RID_FIFO: st_d.r.fifo = wlow;
                RID_BMOD: st_d.r.bmod = wlow;
                RID_BINC: st_d.r.bcnt = wlow;
                RID_MSEC: st_d.r.msec = wlow;
                RID_STS1: st_d.r.sts1 = st_d.r.sts1 & ~(wlow & STS1_W1C);
                RID_STS2: st_d.r.sts2 = st_d.r.sts2 & ~(wlow & STS2_W1C);
                default: ;  // control 4, test, read-only or unmapped
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.r       <= REGS_INIT;
            st_q.tx_stb  <= 1'b0;
            st_q.tx_byte <= '0;
            st_q.irq     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_strobe = st_q.tx_stb;
    assign tx_byte   = st_q.tx_byte;
    assign irq       = st_q.irq;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_en,
    input logic bus_we,
    input logic ie_rx,
    input logic ie_tx,
    input logic ie_txe,
    input logic srst_bit,
    input logic txen_bit,
    input logic rrdy,
    input logic trdy,
    input logic rx_empty,
    input logic [15:0] rxbuf,
    input logic tx_strobe,
    input logic irq
);
    assert_srst_reads_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_bit);

    assert_trdy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trdy);

    assert_rx_flags_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rrdy != rx_empty);

    assert_full_buffer_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rrdy) && !$past(bus_en)) |-> $stable(rxbuf));

    assert_tx_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> ($past(txen_bit) && $past(bus_en) && $past(bus_we)));

    assert_irq_has_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie_rx || (ie_tx && ie_txe)));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .ie_rx     (st_q.r.ctl1[uart_rf_pkg::B_C1_RXIE]),
    .ie_tx     (st_q.r.ctl1[uart_rf_pkg::B_C1_TXIE]),
    .ie_txe    (st_q.r.ctl1[uart_rf_pkg::B_C1_TXEIE]),
    .srst_bit  (st_q.r.ctl2[uart_rf_pkg::B_C2_SRST]),
    .txen_bit  (st_q.r.ctl2[uart_rf_pkg::B_C2_TXEN]),
    .rrdy      (st_q.r.sts1[uart_rf_pkg::B_S1_RRDY]),
    .trdy      (st_q.r.sts1[uart_rf_pkg::B_S1_TRDY]),
    .rx_empty  (st_q.r.test[uart_rf_pkg::B_TS_RXEMP]),
    .rxbuf     (st_q.r.rxbuf),
    .tx_strobe (tx_strobe),
    .irq       (irq)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CLK_NS = 20;

    typedef struct packed {
        logic        wr;
        logic [7:0]  idx;
        logic [31:0] val;   // write data, or expected read value
        logic [3:0]  req;
    } vec_t;

    // R2 masking, R3 dead registers
    localparam vec_t VEC [22] = '{
        '{1'b1, 8'h22, 32'hDEAD0123, 4'd2}, '{1'b0, 8'h22, 32'h00000123, 4'd2},
        '{1'b1, 8'h24, 32'h12345678, 4'd2}, '{1'b0, 8'h24, 32'h00005678, 4'd2},
        '{1'b1, 8'h2A, 32'hFFFF0A0A, 4'd2}, '{1'b0, 8'h2A, 32'h00000A0A, 4'd2},
        '{1'b1, 8'h2C, 32'h000103E8, 4'd2}, '{1'b0, 8'h2C, 32'h000003E8, 4'd2},
        '{1'b1, 8'h29, 32'hABCD0042, 4'd2}, '{1'b0, 8'h2B, 32'h00000042, 4'd2},
        '{1'b0, 8'h29, 32'h00000000, 4'd3},
        '{1'b1, 8'h23, 32'h0000FFFF, 4'd3}, '{1'b0, 8'h23, 32'h00000000, 4'd3},
        '{1'b1, 8'h2D, 32'h00000000, 4'd3}, '{1'b0, 8'h2D, 32'h00000060, 4'd3},
        '{1'b0, 8'h3F, 32'h00000000, 4'd3},
        '{1'b1, 8'h20, 32'h00010001, 4'd2}, '{1'b0, 8'h20, 32'h00000001, 4'd2},
        '{1'b1, 8'h20, 32'h00000000, 4'd2}, '{1'b0, 8'h20, 32'h00000000, 4'd2},
        '{1'b1, 8'h21, 32'h00FF0003, 4'd2}, '{1'b0, 8'h21, 32'h00000003, 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tx_strobe;
    logic [7:0]        tx_byte;
    logic              rx_strobe = 1'b0, rx_break = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              irq;

    int total = 0, fails = 0, tx_cnt = 0;
    logic [7:0] tx_last = '0;
    logic [31:0] rv;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    uart_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .rx_strobe(rx_strobe),
        .rx_break(rx_break), .rx_byte(rx_byte), .irq(irq)
    );

    always @(negedge clk) if (tx_strobe) begin tx_cnt++; tx_last = tx_byte; end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = ADDR_W'({idx, 2'b00}); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] idx, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = ADDR_W'({idx, 2'b00});
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_en = 0;
    endtask

    task automatic push(input logic [7:0] b, input logic brk);
        rx_byte = b; rx_strobe = ~brk; rx_break = brk;
        @(posedge clk); @(negedge clk);
        rx_strobe = 0; rx_break = 0;
    endtask

    task automatic expect_rd(input string req, input logic [7:0] idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        check(req, v, exp);
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R1..: actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 tx_strobe", 32'(tx_strobe), 0);
        expect_rd("R1 sts1", 8'h25, 32'h6040);
        expect_rd("R1 sts2", 8'h26, 32'h4028);
        expect_rd("R1 test", 8'h2D, 32'h0060);
        expect_rd("R1 ctl1", 8'h20, 32'h0000);
        expect_rd("R1 ctl2", 8'h21, 32'h0001);
        expect_rd("R1 ctl3", 8'h22, 32'h0700);
        expect_rd("R1 bmod", 8'h2A, 32'h0000);
        expect_rd("R1 bcnt", 8'h2B, 32'h0004);
        expect_rd("R1 rxd", 8'h00, 32'h4000);

        // vector table: R2, R3
        foreach (VEC[i]) begin
            if (VEC[i].wr) wr(VEC[i].idx, VEC[i].val);
            else begin
                rd(VEC[i].idx, rv);
                check($sformatf("R%0d vec%0d", VEC[i].req, i), rv, VEC[i].val);
            end
        end

        // R8 transmit gating
        wr(8'h10, 32'h1AB);
        @(negedge clk);
        check("R8 no strobe when disabled", 32'(tx_cnt), 0);
        wr(8'h21, 32'h0007);
        wr(8'h10, 32'h1AB);
        @(negedge clk);
        check("R8 strobe count", 32'(tx_cnt), 1);
        check("R8 byte", 32'(tx_last), 32'hAB);
        expect_rd("R8 trdy kept", 8'h25, 32'h6040);

        // R4 / R6 / R7 receive path
        push(8'h41, 0);
        expect_rd("R4 sts1", 8'h25, 32'h6240);
        expect_rd("R4 sts2", 8'h26, 32'h4029);
        expect_rd("R4 test", 8'h2D, 32'h0040);
        push(8'h42, 0);  // dropped: buffer full
        expect_rd("R6 rxd consume (R4 drop)", 8'h00, 32'h8041);
        expect_rd("R6 sts1", 8'h25, 32'h6040);
        expect_rd("R6 sts2", 8'h26, 32'h4028);
        expect_rd("R6 test", 8'h2D, 32'h0060);
        expect_rd("R7 empty read", 8'h00, 32'h0041);
        expect_rd("R7 sts1 unchanged", 8'h25, 32'h6040);

        // R5 break
        push(8'h00, 1);
        expect_rd("R5 break code", 8'h00, 32'h8800);

        // R9 clear masks
        push(8'h33, 0);
        wr(8'h25, 32'hFFFF);
        wr(8'h26, 32'hFFFF);
        expect_rd("R9 sts1", 8'h25, 32'h6240);
        expect_rd("R9 sts2", 8'h26, 32'h4029);
        expect_rd("R9 rxd", 8'h00, 32'h8033);

        // R10 interrupt
        wr(8'h20, 32'h0200);
        push(8'h10, 0);
        check("R10 irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R10 irq rx", 32'(irq), 1);
        rd(8'h00, rv);
        check("R10 irq lag", 32'(irq), 1);
        @(negedge clk);
        check("R10 irq drop", 32'(irq), 0);
        wr(8'h20, 32'h2000);
        repeat (2) @(negedge clk);
        check("R10 tx term gated", 32'(irq), 0);
        wr(8'h20, 32'h2040);
        check("R10 tx lag", 32'(irq), 0);
        @(negedge clk);
        check("R10 tx irq", 32'(irq), 1);

        // R11 software reset
        push(8'h77, 0);
        wr(8'h21, 32'h0006);
        expect_rd("R11 ctl2", 8'h21, 32'h0007);
        expect_rd("R11 ctl1", 8'h20, 32'h0000);
        expect_rd("R11 ctl3", 8'h22, 32'h0700);
        expect_rd("R11 bcnt", 8'h2B, 32'h0004);
        expect_rd("R11 bmod", 8'h2A, 32'h0000);
        expect_rd("R11 sts1", 8'h25, 32'h6040);
        expect_rd("R11 sts2", 8'h26, 32'h4028);
        expect_rd("R11 test", 8'h2D, 32'h0060);
        expect_rd("R11 rxd", 8'h00, 32'h4000);
        expect_rd("R11 fifo kept", 8'h24, 32'h5678);
        expect_rd("R11 msec kept", 8'h2C, 32'h03E8);
        check("R11 irq", 32'(irq), 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule